// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a 32-bit watchdog counter that a host processor drives through a small register interface. The counter counts upward on each pulse of a slow reference tick enable, and it times out when it wraps from all-ones to zero. Software therefore loads the two's-complement negation of the wanted timeout. For example, a 20 second window at a 32768 Hz tick is loaded as the negation of 655360. On a wrap the block pulses a timeout reset output for one clock, raises a sticky overflow flag, and reloads the counter from the load register.

The counter can only be started or stopped with a two-write key handshake on the start/stop register. A write-pending bit models the delay a real slow-domain synchronizer would add. Software polls that bit before and after each key write. A soft reset request clears the whole block over a short fixed sequence, and a status bit reports when the sequence has finished.

The register interface is a simple single-cycle write strobe with a combinational read port. Offsets are byte addresses on an 8-bit bus.

Top module: `wdt_top`

## Requirements
- R1: After reset the block is stopped, the counter reads 0, the load register reads 0xFFFB0000, status bit 0 (offset 0x14) reads 1, and both `wdt_rst_o` and `irq_o` are low.
- R2: While running, the counter increments by one on each clock edge with `tick_en` high. While stopped, ticks leave it unchanged.
- R3: Writing 0xBBBB and then 0x4444 to the start/stop register (offset 0x48, bits 15:0 compared, upper bits ignored) starts the counter. The register reads back the last accepted value.
- R4: Writing 0xAAAA and then 0x5555 to the start/stop register stops the counter.
- R5: If the second write of a key pair does not match the first, the run state is unchanged and the sequence restarts from idle. A lone second key then does nothing.
- R6: Bit 4 of the write-pending register (offset 0x34) is set for exactly 4 clock cycles after an accepted start/stop write. The run state changes on the edge where it clears. Start/stop writes made while the bit is set are ignored.
- R7: On a tick with the counter at 0xFFFFFFFF, the counter reloads from the load register and `wdt_rst_o` is high for one cycle. On the following edge, bit 0 of the interrupt status register (offset 0x18) is set.
- R8: Interrupt status bit 0 is cleared by writing 1 to it. `irq_o` is high while both that bit and bit 0 of the interrupt enable register (offset 0x1C) are set.
- R9: The counter (0x28) and load (0x2C) registers are writable and read back. Any write to the trigger register (0x30) reloads the counter from the load register.
- R10: Writing 1 to bit 1 of the configuration register (0x10) starts a soft reset. For 3 cycles the block is held in its reset state, and status bit 0 reads 0 during that window and 1 afterwards.
- R11: Wake enable (0x20, bit 0) and control (0x24, 32 bits) read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow reference tick, one-cycle enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| wdt_rst_o | output | 1 | One-cycle timeout reset pulse |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that the host changes the run state only through the key register and never writes the counter or trigger in the same cycle it expects a tick to count. They also assume that the soft reset is the only source of clearing besides `rst`.

The stimulus holds `tick_en` low except in explicit tick bursts, so counter values stay predictable. After each key write it waits out the pending window before continuing. The one exception is a back-to-back key write, issued on purpose to show that it is dropped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 8;
    localparam int KEY_W  = 16;

    // Register byte offsets decoded by host software.
    localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ISR   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IER   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_WAKE  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_WPEND = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h48;

    localparam int PEND_BIT = 4;
    localparam int SRST_BIT = 1;

    // Key values for the run-state handshake.
    localparam logic [KEY_W-1:0] KEY_RUN_A  = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_RUN_B  = 16'h4444;
    localparam logic [KEY_W-1:0] KEY_HALT_A = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_HALT_B = 16'h5555;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_RUN_ARMED,
        KS_HALT_ARMED
    } key_state_e;

    typedef struct packed {
        key_state_e state;
        logic       run;
    } key_next_t;

    // Next tracker state and run target for one accepted key write.
    function automatic key_next_t key_step(key_state_e st, logic run_now,
                                           logic [KEY_W-1:0] key);
        key_next_t n;
        n.state = KS_IDLE;
        n.run   = run_now;
        case (st)
            KS_IDLE: begin
                if (key == KEY_RUN_A)       n.state = KS_RUN_ARMED;
                else if (key == KEY_HALT_A) n.state = KS_HALT_ARMED;
            end
            KS_RUN_ARMED:  if (key == KEY_RUN_B)  n.run = 1'b1;
            KS_HALT_ARMED: if (key == KEY_HALT_B) n.run = 1'b0;
            default: n.state = KS_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int PEND_CYC = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wdata,
    output logic             run_o,
    output logic             pend_o,
    output logic [KEY_W-1:0] last_o
);

    localparam int PW = $clog2(PEND_CYC + 1);

    key_state_e       st_q;
    logic             run_q;
    logic             tgt_q;
    logic [PW-1:0]    pend_q;
    logic [KEY_W-1:0] last_q;
    key_next_t        nxt;
    logic             accept;

    assign accept = wr_en && (pend_q == '0);
    assign nxt    = key_step(st_q, run_q, wdata);

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q   <= KS_IDLE;
            run_q  <= 1'b0;
            tgt_q  <= 1'b0;
            pend_q <= '0;
            last_q <= '0;
        end else if (accept) begin
            st_q   <= nxt.state;
            tgt_q  <= nxt.run;
            pend_q <= PW'(PEND_CYC);
            last_q <= wdata;
        end else if (pend_q != '0) begin
            pend_q <= pend_q - PW'(1);
            if (pend_q == PW'(1)) run_q <= tgt_q;
        end
    end

    assign run_o  = run_q;
    assign pend_o = (pend_q != '0);
    assign last_o = last_q;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int          W        = 32,
    parameter logic [W-1:0] LOAD_RST = 32'hFFFB_0000
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic         cnt_we,
    input  logic         load_we,
    input  logic         trig,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] load_o,
    output logic         ovf_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] load_q;
    logic         ovf_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q  <= '0;
            load_q <= LOAD_RST;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_we) load_q <= wdata;
            if (cnt_we) begin
                cnt_q <= wdata;
            end else if (trig) begin
                cnt_q <= load_q;
            end else if (run && tick) begin
                if (cnt_q == '1) begin
                    cnt_q <= load_q;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + W'(1);
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign load_o = load_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/wdt_srst.sv
module wdt_srst #(
    parameter int CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic active_o
);

    localparam int SW = $clog2(CYC + 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q - SW'(1);
        else if (req)           cnt_q <= SW'(CYC);
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int           DW       = 32,
    parameter logic [DW-1:0] LOAD_RST = 32'hFFFB_0000,
    parameter int           PEND_CYC = 4,
    parameter int           SRST_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              wdt_rst_o,
    output logic              irq_o
);

    logic             srst_act;
    logic             clr;
    logic             run_w;
    logic             pend_w;
    logic [KEY_W-1:0] key_last;
    logic [DW-1:0]    cnt_w;
    logic [DW-1:0]    load_w;
    logic             ovf_w;
    logic             key_we, cnt_we, load_we, trig_we;
    logic             cfg_we, isr_we, ier_we, wake_we, ctrl_we;

    logic [DW-1:0]    cfg_q;
    logic [DW-1:0]    ctrl_q;
    logic             isr_q;
    logic             ier_q;
    logic             wake_q;

    assign clr = rst | srst_act;

    assign cfg_we  = reg_wr && (reg_addr == OFS_CFG);
    assign isr_we  = reg_wr && (reg_addr == OFS_ISR);
    assign ier_we  = reg_wr && (reg_addr == OFS_IER);
    assign wake_we = reg_wr && (reg_addr == OFS_WAKE);
    assign ctrl_we = reg_wr && (reg_addr == OFS_CTRL);
    assign cnt_we  = reg_wr && (reg_addr == OFS_CNT);
    assign load_we = reg_wr && (reg_addr == OFS_LOAD);
    assign trig_we = reg_wr && (reg_addr == OFS_TRIG);
    assign key_we  = reg_wr && (reg_addr == OFS_KEY);

    wdt_srst #(.CYC(SRST_CYC)) srst_i (
        .clk      (clk),
        .rst      (rst),
        .req      (cfg_we && reg_wdata[SRST_BIT]),
        .active_o (srst_act)
    );

    wdt_keyseq #(.PEND_CYC(PEND_CYC)) keyseq_i (
        .clk    (clk),
        .clr    (clr),
        .wr_en  (key_we),
        .wdata  (reg_wdata[KEY_W-1:0]),
        .run_o  (run_w),
        .pend_o (pend_w),
        .last_o (key_last)
    );

    wdt_count #(.W(DW), .LOAD_RST(LOAD_RST)) count_i (
        .clk     (clk),
        .clr     (clr),
        .run     (run_w),
        .tick    (tick_en),
        .cnt_we  (cnt_we),
        .load_we (load_we),
        .trig    (trig_we),
        .wdata   (reg_wdata),
        .cnt_o   (cnt_w),
        .load_o  (load_w),
        .ovf_o   (ovf_w)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            cfg_q  <= '0;
            ctrl_q <= '0;
            isr_q  <= 1'b0;
            ier_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (cfg_we)  cfg_q  <= reg_wdata & ~(DW'(1) << SRST_BIT);
            if (ctrl_we) ctrl_q <= reg_wdata;
            if (ier_we)  ier_q  <= reg_wdata[0];
            if (wake_we) wake_q <= reg_wdata[0];
            if (ovf_w)                      isr_q <= 1'b1;
            else if (isr_we && reg_wdata[0]) isr_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:   begin
                reg_rdata           = cfg_q;
                reg_rdata[SRST_BIT] = srst_act;
            end
            OFS_STAT:  reg_rdata[0] = ~srst_act;
            OFS_ISR:   reg_rdata[0] = isr_q;
            OFS_IER:   reg_rdata[0] = ier_q;
            OFS_WAKE:  reg_rdata[0] = wake_q;
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_CNT:   reg_rdata = cnt_w;
            OFS_LOAD:  reg_rdata = load_w;
            OFS_WPEND: reg_rdata[PEND_BIT] = pend_w;
            OFS_KEY:   reg_rdata[KEY_W-1:0] = key_last;
            default:   reg_rdata = '0;
        endcase
    end

    assign wdt_rst_o = ovf_w;
    assign irq_o     = isr_q & ier_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          srst_act,
    input logic          run,
    input logic          pend,
    input logic          key_we,
    input logic          cnt_we,
    input logic          trig_we,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] load,
    input logic          ovf,
    input logic          isr
);

    AST_RUN_ON_PEND_END: assert property (@(posedge clk) disable iff (rst)
        (!$stable(run) && !$past(clr)) |-> $fell(pend)); // R6

    AST_PEND_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        (key_we && !pend && !clr) |=> pend); // R6

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we && !trig_we && !clr) |=> $stable(cnt)); // R2

    AST_OVF_RELOADS: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == $past(load))); // R7

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> isr); // R7

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(srst_act) |-> (cnt == '0 && !run && !pend && !isr)); // R10

endmodule

bind wdt_top wdt_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .srst_act (srst_act),
    .run      (run_w),
    .pend     (pend_w),
    .key_we   (key_we),
    .cnt_we   (cnt_we),
    .trig_we  (trig_we),
    .cnt      (cnt_w),
    .load     (load_w),
    .ovf      (ovf_w),
    .isr      (isr_q)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_ID = 2'd2;
    localparam logic [1:0] OP_TK = 2'd3;

    localparam logic [7:0] A_CFG = 8'h10, A_STAT = 8'h14, A_ISR = 8'h18,
                           A_IER = 8'h1C, A_WAKE = 8'h20, A_CTRL = 8'h24,
                           A_CNT = 8'h28, A_LOAD = 8'h2C, A_TRIG = 8'h30,
                           A_WPEND = 8'h34, A_KEY = 8'h48;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, A_STAT,  32'h0000_0001, 4'd1},  // R1
        '{OP_RD, A_CNT,   32'h0000_0000, 4'd1},  // R1
        '{OP_RD, A_LOAD,  32'hFFFB_0000, 4'd1},  // R1
        '{OP_WR, A_LOAD,  32'hFFFF_FFF0, 4'd9},
        '{OP_RD, A_LOAD,  32'hFFFF_FFF0, 4'd9},  // R9
        '{OP_WR, A_CNT,   32'hFFFF_FFFA, 4'd9},
        '{OP_RD, A_CNT,   32'hFFFF_FFFA, 4'd9},  // R9
        '{OP_TK, 8'h00,   32'd3,         4'd2},
        '{OP_RD, A_CNT,   32'hFFFF_FFFA, 4'd2},  // R2 stopped holds
        '{OP_WR, A_IER,   32'h0000_0001, 4'd8},
        '{OP_RD, A_IER,   32'h0000_0001, 4'd8},  // R8
        '{OP_WR, A_WAKE,  32'h0000_0001, 4'd11},
        '{OP_RD, A_WAKE,  32'h0000_0001, 4'd11}, // R11
        '{OP_WR, A_CTRL,  32'h0000_00A5, 4'd11},
        '{OP_RD, A_CTRL,  32'h0000_00A5, 4'd11}, // R11
        '{OP_WR, A_KEY,   32'h0000_BBBB, 4'd3},
        '{OP_RD, A_WPEND, 32'h0000_0010, 4'd6},  // R6 pending set
        '{OP_ID, 8'h00,   32'd4,         4'd6},
        '{OP_RD, A_WPEND, 32'h0000_0000, 4'd6},  // R6 pending clear
        '{OP_WR, A_KEY,   32'h0000_4444, 4'd3},
        '{OP_ID, 8'h00,   32'd5,         4'd3},
        '{OP_TK, 8'h00,   32'd3,         4'd3},
        '{OP_RD, A_CNT,   32'hFFFF_FFFD, 4'd3},  // R3 R2 running
        '{OP_TK, 8'h00,   32'd3,         4'd7},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd7},  // R7 reload
        '{OP_RD, A_ISR,   32'h0000_0001, 4'd7},  // R7 flag
        '{OP_WR, A_ISR,   32'h0000_0001, 4'd8},
        '{OP_RD, A_ISR,   32'h0000_0000, 4'd8},  // R8 W1C
        '{OP_WR, A_KEY,   32'h0000_AAAA, 4'd4},
        '{OP_ID, 8'h00,   32'd5,         4'd4},
        '{OP_WR, A_KEY,   32'h0000_5555, 4'd4},
        '{OP_ID, 8'h00,   32'd5,         4'd4},
        '{OP_TK, 8'h00,   32'd4,         4'd4},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd4},  // R4 stopped
        '{OP_WR, A_KEY,   32'h0000_BBBB, 4'd5},
        '{OP_ID, 8'h00,   32'd5,         4'd5},
        '{OP_WR, A_KEY,   32'h0000_1234, 4'd5},
        '{OP_ID, 8'h00,   32'd5,         4'd5},
        '{OP_TK, 8'h00,   32'd2,         4'd5},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd5},  // R5 mismatch
        '{OP_WR, A_KEY,   32'h0000_4444, 4'd5},
        '{OP_ID, 8'h00,   32'd5,         4'd5},
        '{OP_TK, 8'h00,   32'd2,         4'd5},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd5},  // R5 lone second key
        '{OP_WR, A_CNT,   32'h0000_0000, 4'd9},
        '{OP_WR, A_TRIG,  32'h0000_0000, 4'd9},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd9},  // R9 trigger
        '{OP_WR, A_KEY,   32'h0000_BBBB, 4'd6},
        '{OP_WR, A_KEY,   32'h0000_4444, 4'd6},  // dropped: pending
        '{OP_ID, 8'h00,   32'd5,         4'd6},
        '{OP_TK, 8'h00,   32'd2,         4'd6},
        '{OP_RD, A_CNT,   32'hFFFF_FFF0, 4'd6},  // R6 ignored write
        '{OP_RD, A_KEY,   32'h0000_BBBB, 4'd6},  // R6 R3 readback
        '{OP_WR, A_KEY,   32'h0000_4444, 4'd3},
        '{OP_ID, 8'h00,   32'd5,         4'd3},
        '{OP_TK, 8'h00,   32'd2,         4'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wdt_rst_o;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdt_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wdt_rst_o (wdt_rst_o),
        .irq_o     (irq_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, req);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check({30'b0, wdt_rst_o, irq_o}, 32'h0, 1); // R1 outputs low

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: wr(VECS[i].addr, VECS[i].data);
                OP_RD: rd(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
                OP_ID: repeat (VECS[i].data) @(negedge clk);
                default: ticks(int'(VECS[i].data));
            endcase
        end
        rd(A_CNT, 32'hFFFF_FFF2, 3); // R3 restart after dropped write

        // R7 timeout pulse width and interrupt
        wr(A_CNT, 32'hFFFF_FFFF);
        reg_addr = A_CNT;
        ticks(1);
        #1;
        check({31'b0, wdt_rst_o}, 32'h1, 7);   // R7 pulse
        check(reg_rdata, 32'hFFFF_FFF0, 7);    // R7 reload
        @(negedge clk);
        #1;
        check({31'b0, wdt_rst_o}, 32'h0, 7);   // R7 single cycle
        check({31'b0, irq_o}, 32'h1, 8);       // R8 irq raised
        wr(A_ISR, 32'h1);
        #1;
        check({31'b0, irq_o}, 32'h0, 8);       // R8 irq cleared

        // R10 soft reset
        wr(A_LOAD, 32'h0000_1234);
        wr(A_CFG, 32'h0000_0002);
        rd(A_STAT, 32'h0, 10);                 // R10 busy
        repeat (3) @(negedge clk);
        rd(A_STAT, 32'h1, 10);                 // R10 done
        rd(A_LOAD, 32'hFFFB_0000, 10);
        rd(A_IER, 32'h0, 10);
        rd(A_WAKE, 32'h0, 10);
        ticks(2);
        rd(A_CNT, 32'h0, 10);                  // R10 stopped after clear

        rd(8'h40, 32'h0, 11);                  // R11 unmapped
        rd(8'h00, 32'h0, 11);                  // R11 unmapped

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule